// File: doc/BRIEF.md
# Serial Wiper Command Engine

This block takes 24-bit command frames from a serial host and uses them to manage two 10-bit wiper registers, which are the digital settings of a dual potentiometer. Behind the wipers sits a sixteen-entry array of 16-bit words that stands in for nonvolatile storage. Entries 0 and 1 hold the saved settings for the two wipers. The other entries are free for user data. After any write or restore, the array reports itself busy for a set number of clock cycles.

The host pulls chip select low and clocks in bits, most significant first. When chip select is released, the engine decodes the frame and carries it out. The command set covers direct loads, save and recall between the wipers and the array, increments and decrements that stop at the limits, doubling and halving that also stop at the limits, readback, and pass-through for daisy chains. Every serial input is brought into the system clock domain by synchronizers and sampled there. A write-guard input locks the array against changes. A restore strobe reloads both wipers from the array.

Top module: `dpot_cmd_engine`

## Requirements
- R1: A frame is a burst of exactly 24 bits sampled on rising serial clock edges while chip select is low. Bits 23:20 hold the command, bits 19:16 the address and bits 15:0 the data. The command takes effect only after chip select rises. A burst of any other length changes no state.
- R2: Command 11 writes data bits 9:0 to the wiper chosen by address bit 0 (0 is wiper A, 1 is wiper B). Command 3 writes all 16 data bits to array entry address[3:0].
- R3: Command 14 adds one to the chosen wiper and command 15 adds one to both, holding at 0x3FF. Command 6 subtracts one from the chosen wiper and command 7 from both, holding at 0.
- R4: Command 12 doubles the chosen wiper and command 13 doubles both, by a left shift that gives 0x3FF whenever the result would overflow, so 0x200 doubles to 0x3FF. Command 4 halves the chosen wiper and command 5 halves both, by a right shift that stops at 0.
- R5: The increment, decrement, doubling and halving commands do not depend on the data bits of their frame.
- R6: Command 2 stores the chosen wiper, zero-extended, into entry address bit 0. Command 1 loads the chosen wiper from the low 10 bits of that entry. Command 8 loads wiper A from entry 0 and wiper B from entry 1, also using only the low 10 bits.
- R7: Command 1 sets the recall_flag output. Command 0 clears it.
- R8: The serial output presents bit 23 of a 24-bit shift register, and each sampled input bit is shifted into that register. A full frame therefore sends out the 24 bits of the previous frame, most significant bit first.
- R9: After command 9 (read entry address[3:0]) or command 10 (read the chosen wiper, zero-extended), the next frame sends out the read frame's top 8 bits followed by the 16-bit value read.
- R10: While wr_guard is high, commands 2 and 3 leave the array unchanged.
- R11: ready goes low for BUSY_CYCLES clock cycles after reset and after every array write or restore (commands 1, 2, 3 and 8, and the restore strobe). Frames that complete while ready is low are ignored.
- R12: After reset, entries 0 and 1 hold INIT_WIPER, all other entries hold 0, and both wipers equal INIT_WIPER. A falling edge on restore_n reloads both wipers from entries 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; acts as power-on restore |
| sclk | input | 1 | Serial clock; input is sampled on its rising edge |
| cs_n | input | 1 | Active-low frame select; its release executes the frame |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdo | output | 1 | Serial data out (daisy-chain or readback) |
| wr_guard | input | 1 | High locks the array against commands 2 and 3 |
| restore_n | input | 1 | Falling edge reloads both wipers from the array |
| ready | output | 1 | Low while the array is busy |
| recall_flag | output | 1 | Set by command 1, cleared by command 0 |
| wiper_a | output | WIPER_W | Wiper A setting |
| wiper_b | output | WIPER_W | Wiper B setting |

## Verification
The assertions check on every cycle that the wipers hold steady when no frame executes and while the array is busy. They also check that the write guard suppresses array writes, that a busy period begins right after each array operation, that the bit counter clears at the start of a frame, and that the step logic never moves a wiper the wrong way. Only the bench scenarios can show the following: the actual saturation values across doubling, halving and step sweeps; the contents of all sixteen entries after writes; the exact bit stream at the serial output, including readback replacing the pass-through data; and whether short frames and frames sent while busy are dropped.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam int FRAME_BITS = 24;
   localparam int CMD_W      = 4;
   localparam int ADR_W      = 4;
   localparam int DATA_W     = 16;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP     = 4'd0,
      CMD_RECALL  = 4'd1,
      CMD_SAVE    = 4'd2,
      CMD_MEMWR   = 4'd3,
      CMD_HALF1   = 4'd4,
      CMD_HALFALL = 4'd5,
      CMD_DEC1    = 4'd6,
      CMD_DECALL  = 4'd7,
      CMD_RELOAD  = 4'd8,
      CMD_MEMRD   = 4'd9,
      CMD_WIPRD   = 4'd10,
      CMD_WIPWR   = 4'd11,
      CMD_DBL1    = 4'd12,
      CMD_DBLALL  = 4'd13,
      CMD_INC1    = 4'd14,
      CMD_INCALL  = 4'd15
   } cmd_e;

   typedef enum logic [2:0] {
      STEP_NONE   = 3'd0,
      STEP_HALF   = 3'd1,
      STEP_DOUBLE = 3'd2,
      STEP_DEC    = 3'd3,
      STEP_INC    = 3'd4
   } step_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dpot_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dpot_serial_rx.sv
module dpot_serial_rx
   import dpot_pkg::*;
#(
   parameter int NBITS = FRAME_BITS,
   parameter int LOADW = DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_s,
   input  logic             cs_n_s,
   input  logic             sdi_s,
   input  logic             load_en,
   input  logic [LOADW-1:0] load_data,
   output logic             frame_ok,
   output logic [NBITS-1:0] frame_word,
   output logic             sdo
);
   localparam int CNT_W   = $clog2(NBITS + 2);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);

   if (LOADW > NBITS) begin : g_bad_load
      $error("dpot_serial_rx: LOADW exceeds NBITS");
   end

   logic             sclk_d, cs_d;
   logic             sclk_rise, cs_rise, cs_fall;
   logic [CNT_W-1:0] bit_cnt;
   logic [NBITS-1:0] shreg;

   assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
   assign cs_rise   = cs_n_s & ~cs_d;
   assign cs_fall   = ~cs_n_s & cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bit_cnt <= '0;
      else if (cs_fall)                        bit_cnt <= '0;
      else if (sclk_rise && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shreg <= '0;
      else if (sclk_rise) shreg <= {shreg[NBITS-2:0], sdi_s};
      else if (load_en)   shreg[LOADW-1:0] <= load_data;
   end

   assign frame_ok   = cs_rise && (bit_cnt == CNT_FULL);
   assign frame_word = shreg;
   assign sdo        = shreg[NBITS-1];

   // R1: a new frame restarts the bit count
   p_cnt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (bit_cnt == '0));
   // R8: each sampled bit lands at the bottom of the shift register
   p_shift_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> (shreg[0] == $past(sdi_s)));
   // R8: without a shift or a readback load the register holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_rise && !load_en) |=> $stable(shreg));
endmodule

// File: rtl/dpot_step.sv
module dpot_step
   import dpot_pkg::*;
#(
   parameter int W = 10
) (
   input  logic [W-1:0] val,
   input  step_e        op,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] ONES = '1;

   always_comb begin
      unique case (op)
         STEP_HALF:   nxt = val >> 1;
         STEP_DOUBLE: nxt = val[W-1] ? ONES : (val << 1);
         STEP_DEC:    nxt = (val == '0) ? val : val - 1'b1;
         STEP_INC:    nxt = (val == ONES) ? val : val + 1'b1;
         default:     nxt = val;
      endcase
   end

   always_comb begin
      if (!$isunknown({val, op})) begin
         if (op == STEP_INC || op == STEP_DOUBLE) begin
            p_up_sat_r3: assert (nxt >= val);    // R3/R4 never wraps downward
         end
         if (op == STEP_DEC || op == STEP_HALF) begin
            p_down_sat_r4: assert (nxt <= val);  // R3/R4 never wraps upward
         end
      end
   end
endmodule

// File: rtl/dpot_nvm.sv
module dpot_nvm #(
   parameter int             DEPTH       = 16,
   parameter int             DW          = 16,
   parameter int             WIPER_W     = 10,
   parameter logic [WIPER_W-1:0] INIT_WIPER = 10'h200,
   parameter int             BUSY_CYCLES = 64,
   localparam int            AW          = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [DW-1:0]      wdata,
   input  logic               start_busy,
   input  logic [AW-1:0]      raddr,
   output logic [DW-1:0]      rdata,
   output logic [WIPER_W-1:0] slot0,
   output logic [WIPER_W-1:0] slot1,
   output logic               ready
);
   localparam int BW = $clog2(BUSY_CYCLES + 1);

   if (WIPER_W > DW) begin : g_bad_width
      $error("dpot_nvm: WIPER_W exceeds DW");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("dpot_nvm: two wiper slots are required");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("dpot_nvm: BUSY_CYCLES must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [BW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= (i < 2) ? DW'(INIT_WIPER) : '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               busy_cnt <= BW'(BUSY_CYCLES);
      else if (start_busy)      busy_cnt <= BW'(BUSY_CYCLES);
      else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
   end

   assign rdata = mem[raddr];
   assign slot0 = mem[0][WIPER_W-1:0];
   assign slot1 = mem[1][WIPER_W-1:0];
   assign ready = (busy_cnt == '0);

   // R11: every array operation opens a busy window on the next cycle
   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_busy |=> !ready);
   // R11: ready only rises after a countdown, never straight after a start
   p_ready_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(!start_busy));
endmodule

// File: rtl/dpot_cmd_engine.sv
module dpot_cmd_engine
   import dpot_pkg::*;
#(
   parameter int                 WIPER_W     = 10,
   parameter int                 DEPTH       = 16,
   parameter int                 BUSY_CYCLES = 64,
   parameter logic [WIPER_W-1:0] INIT_WIPER  = 10'h200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               sdi,
   output logic               sdo,
   input  logic               wr_guard,
   input  logic               restore_n,
   output logic               ready,
   output logic               recall_flag,
   output logic [WIPER_W-1:0] wiper_a,
   output logic [WIPER_W-1:0] wiper_b
);
   localparam int NUM_W = 2;
   localparam int AW    = $clog2(DEPTH);

   if (DEPTH != (1 << ADR_W)) begin : g_bad_depth
      $error("dpot_cmd_engine: DEPTH must match the 4-bit address field");
   end
   if (WIPER_W > DATA_W) begin : g_bad_wiper
      $error("dpot_cmd_engine: WIPER_W exceeds the data field");
   end

   // ---------------- input synchronisation ----------------
   logic [4:0] raw_in, syn_in;
   logic       sclk_s, cs_n_s, sdi_s, restore_s, guard_s;
   assign raw_in = {wr_guard, sclk, cs_n, sdi, restore_n};

   dpot_sync #(.W(5), .STAGES(2), .RST_VAL(5'b00101)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

   assign {guard_s, sclk_s, cs_n_s, sdi_s, restore_s} = syn_in;

   logic restore_d, preset_fire;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) restore_d <= 1'b1;
      else        restore_d <= restore_s;
   end
   assign preset_fire = restore_d & ~restore_s;

   // ---------------- serial frame receiver ----------------
   logic                  frame_ok, rb_en;
   logic [FRAME_BITS-1:0] frame_word;
   logic [DATA_W-1:0]     rb_data;

   dpot_serial_rx #(.NBITS(FRAME_BITS), .LOADW(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
      .load_en(rb_en), .load_data(rb_data), .frame_ok(frame_ok),
      .frame_word(frame_word), .sdo(sdo));

   // ---------------- memory array ----------------
   logic               mem_we, busy_go;
   logic [AW-1:0]      mem_wa;
   logic [DATA_W-1:0]  mem_wd, mem_rd;
   logic [WIPER_W-1:0] slot [NUM_W];

   dpot_nvm #(.DEPTH(DEPTH), .DW(DATA_W), .WIPER_W(WIPER_W),
              .INIT_WIPER(INIT_WIPER), .BUSY_CYCLES(BUSY_CYCLES)) u_nvm (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
      .start_busy(busy_go), .raddr(frame_word[19:16]), .rdata(mem_rd),
      .slot0(slot[0]), .slot1(slot[1]), .ready(ready));

   // ---------------- decode ----------------
   cmd_e               cmd;
   logic [ADR_W-1:0]   adr;
   logic [DATA_W-1:0]  dat;
   logic               sel, exec_go, flag_set, flag_clr;
   logic [WIPER_W-1:0] wip    [NUM_W];
   logic [WIPER_W-1:0] nxt    [NUM_W];
   logic [WIPER_W-1:0] ld_val [NUM_W];
   logic               ld_en  [NUM_W];
   step_e              op     [NUM_W];

   assign cmd     = cmd_e'(frame_word[23:20]);
   assign adr     = frame_word[19:16];
   assign dat     = frame_word[15:0];
   assign sel     = adr[0];
   assign exec_go = frame_ok && ready && !preset_fire;

   always_comb begin
      mem_we   = 1'b0;
      mem_wa   = adr;
      mem_wd   = dat;
      busy_go  = 1'b0;
      rb_en    = 1'b0;
      rb_data  = mem_rd;
      flag_set = 1'b0;
      flag_clr = 1'b0;
      for (int i = 0; i < NUM_W; i++) begin
         ld_en[i]  = 1'b0;
         ld_val[i] = dat[WIPER_W-1:0];
         op[i]     = STEP_NONE;
      end
      if (preset_fire) begin
         busy_go = 1'b1;
         for (int i = 0; i < NUM_W; i++) begin
            ld_en[i]  = 1'b1;
            ld_val[i] = slot[i];
         end
      end else if (exec_go) begin
         unique case (cmd)
            CMD_NOP:    flag_clr = 1'b1;
            CMD_RECALL: begin
               ld_en[sel]  = 1'b1;
               ld_val[sel] = slot[sel];
               flag_set    = 1'b1;
               busy_go     = 1'b1;
            end
            CMD_SAVE: if (!guard_s) begin
               mem_we  = 1'b1;
               mem_wa  = AW'(sel);
               mem_wd  = DATA_W'(wip[sel]);
               busy_go = 1'b1;
            end
            CMD_MEMWR: if (!guard_s) begin
               mem_we  = 1'b1;
               busy_go = 1'b1;
            end
            CMD_HALF1:   op[sel] = STEP_HALF;
            CMD_DEC1:    op[sel] = STEP_DEC;
            CMD_DBL1:    op[sel] = STEP_DOUBLE;
            CMD_INC1:    op[sel] = STEP_INC;
            CMD_HALFALL: for (int i = 0; i < NUM_W; i++) op[i] = STEP_HALF;
            CMD_DECALL:  for (int i = 0; i < NUM_W; i++) op[i] = STEP_DEC;
            CMD_DBLALL:  for (int i = 0; i < NUM_W; i++) op[i] = STEP_DOUBLE;
            CMD_INCALL:  for (int i = 0; i < NUM_W; i++) op[i] = STEP_INC;
            CMD_RELOAD: begin
               busy_go = 1'b1;
               for (int i = 0; i < NUM_W; i++) begin
                  ld_en[i]  = 1'b1;
                  ld_val[i] = slot[i];
               end
            end
            CMD_MEMRD: rb_en = 1'b1;
            CMD_WIPRD: begin
               rb_en   = 1'b1;
               rb_data = DATA_W'(wip[sel]);
            end
            CMD_WIPWR: ld_en[sel] = 1'b1;
            default: ;
         endcase
      end
   end

   // ---------------- wiper registers ----------------
   for (genvar g = 0; g < NUM_W; g++) begin : g_wiper
      dpot_step #(.W(WIPER_W)) u_step (.val(wip[g]), .op(op[g]), .nxt(nxt[g]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                wip[g] <= INIT_WIPER;
         else if (ld_en[g])         wip[g] <= ld_val[g];
         else if (op[g] != STEP_NONE) wip[g] <= nxt[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        recall_flag <= 1'b0;
      else if (flag_set) recall_flag <= 1'b1;
      else if (flag_clr) recall_flag <= 1'b0;
   end

   assign wiper_a = wip[0];
   assign wiper_b = wip[1];

   // R1: wipers change only when a frame executes or the strobe fires
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_go && !preset_fire) |=> ($stable(wiper_a) && $stable(wiper_b)));
   // R11: a busy array blocks frame execution
   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !preset_fire) |=> ($stable(wiper_a) && $stable(wiper_b)));
   // R10: the guard keeps the array untouched
   p_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      guard_s |-> !mem_we);
   // R7: a recall leaves the flag raised
   p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_go && cmd == CMD_RECALL) |=> recall_flag);
endmodule

// File: tb/dpot_cmd_engine_bench.sv
module dpot_cmd_engine_bench;
   localparam int BUSY = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic wr_guard = 1'b0, restore_n = 1'b1;
   logic sdo, ready, recall_flag;
   logic [9:0] wiper_a, wiper_b;

   always #4 clk = ~clk;

   dpot_cmd_engine #(.WIPER_W(10), .DEPTH(16), .BUSY_CYCLES(BUSY),
                     .INIT_WIPER(10'h200)) u_dpot_cmd_engine (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
      .wr_guard(wr_guard), .restore_n(restore_n), .ready(ready),
      .recall_flag(recall_flag), .wiper_a(wiper_a), .wiper_b(wiper_b));

   int n_chk = 0, n_bad = 0;
   logic [9:0]  mw [2];
   logic [15:0] mm [16];
   logic        mflag;
   logic [23:0] exp_out, got;
   string       exp_tag;
   bit          skip_sdo;
   logic [9:0]  pre_rise_a;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] sat(input int v);
      return (v > 1023) ? 10'h3FF : (v < 0) ? 10'h000 : 10'(v);
   endfunction

   task automatic model_exec(input logic [23:0] w);
      logic [3:0] c, a;
      logic       s;
      c = w[23:20]; a = w[19:16]; s = a[0];
      case (c)
         4'd0:  mflag = 1'b0;
         4'd1:  begin mw[s] = mm[s][9:0]; mflag = 1'b1; end
         4'd2:  if (!wr_guard) mm[s] = {6'b0, mw[s]};
         4'd3:  if (!wr_guard) mm[a] = w[15:0];
         4'd4:  mw[s] = mw[s] / 2;
         4'd5:  for (int i = 0; i < 2; i++) mw[i] = mw[i] / 2;
         4'd6:  mw[s] = sat(int'(mw[s]) - 1);
         4'd7:  for (int i = 0; i < 2; i++) mw[i] = sat(int'(mw[i]) - 1);
         4'd8:  for (int i = 0; i < 2; i++) mw[i] = mm[i][9:0];
         4'd9:  begin exp_out = {w[23:16], mm[a]}; exp_tag = "R9"; end
         4'd10: begin exp_out = {w[23:16], 6'b0, mw[s]}; exp_tag = "R9"; end
         4'd11: mw[s] = w[9:0];
         4'd12: mw[s] = sat(int'(mw[s]) * 2);
         4'd13: for (int i = 0; i < 2; i++) mw[i] = sat(int'(mw[i]) * 2);
         4'd14: mw[s] = sat(int'(mw[s]) + 1);
         default: for (int i = 0; i < 2; i++) mw[i] = sat(int'(mw[i]) + 1);
      endcase
   endtask

   task automatic xfer(input logic [23:0] w, input int nb, input bit rdy_wait);
      got = '0;
      cs_n = 1'b0;
      tick(4);
      for (int b = 0; b < nb; b++) begin
         sdi = w[23-b];
         tick(4);
         got[23-b] = sdo;
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
      end
      tick(6);
      pre_rise_a = wiper_a;
      cs_n = 1'b1;
      tick(8);
      if (rdy_wait) begin
         for (int g = 0; g < 5000 && !ready; g++) tick(1);
         tick(2);
      end
   endtask

   task automatic do_frame(input string req, input logic [23:0] w, input int nb,
                           input bit rdy_wait, input bit run);
      xfer(w, nb, rdy_wait);
      if (!skip_sdo && nb == 24) chk(exp_tag, 32'(got), 32'(exp_out));
      skip_sdo = (nb != 24);
      exp_out  = w;
      exp_tag  = "R8";
      if (run) model_exec(w);
      chk(req, 32'(wiper_a), 32'(mw[0]));
      chk(req, 32'(wiper_b), 32'(mw[1]));
      chk("R7", 32'(recall_flag), 32'(mflag));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      mw[0] = 10'h200; mw[1] = 10'h200; mflag = 1'b0;
      for (int i = 0; i < 16; i++) mm[i] = (i < 2) ? 16'h0200 : 16'h0000;
      exp_out = '0; exp_tag = "R8"; skip_sdo = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(4);
      // reset state
      chk("R12", 32'(wiper_a), 32'h200);
      chk("R12", 32'(wiper_b), 32'h200);
      chk("R11", 32'(ready), 32'h0);
      chk("R7",  32'(recall_flag), 32'h0);
      chk("R8",  32'(sdo), 32'h0);
      for (int g = 0; g < 5000 && !ready; g++) tick(1);
      chk("R11", 32'(ready), 32'h1);

      // direct wiper loads; execution waits for chip select release
      do_frame("R2", 24'hB00100, 24, 1, 1);
      chk("R1", 32'(pre_rise_a), 32'h200);
      do_frame("R2", 24'hB1F200, 24, 1, 1);

      // increment saturation with varying data bits (R5)
      do_frame("R2", 24'hB003FC, 24, 1, 1);
      for (int k = 0; k < 5; k++) do_frame("R3", {8'hE0, 16'(k * 16'h3A5B)}, 24, 1, 1);
      do_frame("R2", 24'hB10003, 24, 1, 1);
      for (int k = 0; k < 5; k++) do_frame("R3", {8'h61, 16'(k * 16'hC3C3)}, 24, 1, 1);
      for (int k = 0; k < 3; k++) do_frame("R3", 24'h7FFFFF, 24, 1, 1);
      for (int k = 0; k < 4; k++) do_frame("R3", 24'hF00000, 24, 1, 1);

      // doubling and halving sweeps
      do_frame("R2", 24'hB00001, 24, 1, 1);
      for (int k = 0; k < 12; k++) do_frame("R4", {8'hC0, 16'(k * 16'h1111)}, 24, 1, 1);
      do_frame("R2", 24'hB10200, 24, 1, 1);
      do_frame("R4", 24'hC1ABCD, 24, 1, 1);
      chk("R4", 32'(wiper_b), 32'h3FF);
      for (int k = 0; k < 12; k++) do_frame("R4", {8'h50, 16'(k * 16'h0F0F)}, 24, 1, 1);
      do_frame("R2", 24'hB00155, 24, 1, 1);
      do_frame("R4", 24'h40FFFF, 24, 1, 1);
      do_frame("R4", 24'hD00000, 24, 1, 1);
      do_frame("R5", 24'h410000, 24, 1, 1);

      // array writes and readback across all entries
      for (int a = 0; a < 16; a++)
         do_frame("R2", {4'h3, 4'(a), 16'((a * 16'h1111) ^ 16'hA5A5)}, 24, 1, 1);
      for (int a = 0; a < 16; a++) do_frame("R9", {4'h9, 4'(a), 16'hFFFF}, 24, 1, 1);
      do_frame("R9", 24'hA10000, 24, 1, 1);
      do_frame("R9", 24'hA00000, 24, 1, 1);
      do_frame("R9", 24'h000000, 24, 1, 1);

      // save, recall, reload
      do_frame("R2", 24'hB00155, 24, 1, 1);
      do_frame("R6", 24'h200000, 24, 1, 1);
      do_frame("R6", 24'h90FFFF, 24, 1, 1);
      do_frame("R6", 24'h31FC3A, 24, 1, 1);
      do_frame("R6", 24'h800000, 24, 1, 1);
      chk("R6", 32'(wiper_b), 32'h03A);
      do_frame("R2", 24'hB00000, 24, 1, 1);
      do_frame("R6", 24'h100000, 24, 1, 1);
      chk("R7", 32'(recall_flag), 32'h1);
      do_frame("R7", 24'h000000, 24, 1, 1);
      chk("R7", 32'(recall_flag), 32'h0);

      // write guard
      wr_guard = 1'b1;
      tick(4);
      do_frame("R10", 24'h351234, 24, 1, 1);
      do_frame("R10", 24'hB1007F, 24, 1, 1);
      do_frame("R10", 24'h210000, 24, 1, 1);
      do_frame("R10", 24'h950000, 24, 1, 1);
      do_frame("R10", 24'h910000, 24, 1, 1);
      do_frame("R10", 24'h000000, 24, 1, 1);
      wr_guard = 1'b0;
      tick(4);

      // busy window drops a frame
      do_frame("R11", 24'h344321, 24, 0, 1);
      chk("R11", 32'(ready), 32'h0);
      do_frame("R11", 24'hB00011, 24, 0, 0);
      for (int g = 0; g < 5000 && !ready; g++) tick(1);
      chk("R11", 32'(ready), 32'h1);
      do_frame("R11", 24'h940000, 24, 1, 1);

      // short frame is discarded
      do_frame("R1", 24'hB00077, 16, 1, 0);
      do_frame("R1", 24'hB10099, 23, 1, 0);
      do_frame("R1", 24'h000000, 24, 1, 1);

      // restore strobe
      do_frame("R12", 24'h300123, 24, 1, 1);
      do_frame("R12", 24'h310321, 24, 1, 1);
      do_frame("R12", 24'hB00001, 24, 1, 1);
      restore_n = 1'b0;
      tick(6);
      restore_n = 1'b1;
      tick(6);
      chk("R11", 32'(ready), 32'h0);
      for (int g = 0; g < 5000 && !ready; g++) tick(1);
      chk("R12", 32'(wiper_a), 32'h123);
      chk("R12", 32'(wiper_b), 32'h321);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule